// File: doc/BRIEF.md
# Paged Remote DMA Engine

The engine moves bytes between a host data port and a local packet memory. The host sets it up through small byte-wide registers. It writes a 16-bit current address as two bytes and a 16-bit byte count as two bytes. It then starts a transfer by writing a 3-bit command code. After that, every strobe on the data port moves one byte, or one 16-bit word in word mode. Each strobe also advances the address and lowers the count. When the count runs out, the engine returns to idle and raises a completion flag that the host can poll.

For a read transfer, the engine fetches the next memory location into a holding register ahead of time. The data port therefore presents valid data as soon as the engine is armed and again after every access, with no wait states. The host can read the current address at any time, so it can see where the next data-port access will land.

Top module: `rdma_engine`

## Requirements
- R1: After reset the engine is idle, the current address, the remaining count and the completion flag are zero, the command readback at register offset 0 is 0x20 (code 4 in bits 5:3), and the data port output is zero.
- R2: A host write to offset 2 loads the low byte of the current address, and a write to offset 3 loads the high byte. The value is readable at offset 6 (low byte) and offset 7 (high byte) from the next cycle on.
- R3: The remaining count is written at offset 4 (low byte) and offset 5 (high byte) and is readable there. Offset 0 holds the command field in bits 5:3. Writing code 1 (read) or code 2 (write) arms the engine only if the count is nonzero. Writing code 3 or any other code has no effect. The readback shows 1 or 2 while a transfer is armed and 4 while idle.
- R4: While a write transfer is armed, each data-port write stores the byte at the current address, increments the address by 1 and decrements the count by 1.
- R5: While a read transfer is armed, the data port output holds the byte at the current address. This holds from the cycle after arming and again in the cycle after each data-port read, which advances the address by 1 and the count by -1.
- R6: With word mode set, each access moves 16 bits, with the low byte at the lower address. The address advances by 2 and the count drops by 2, and a count below 2 counts as exhausted. A byte-mode read of the same data returns the low byte first.
- R7: The completion flag (offset 1, bit 6) is set once, by the access that brings the count to zero, and that access also returns the engine to idle. Writing 1 to bit 6 clears the flag, and a completing access in the same cycle wins over the clear.
- R8: Writing code 4 (abort) stops a transfer in progress. The address and count keep their values and the completion flag is not set.
- R9: A data-port access while the engine is idle, or one in the opposite direction to the armed transfer, changes neither memory, address nor count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Single-cycle register write strobe |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on reg_addr_i) |
| word_mode_i | input | 1 | 1 = 16-bit data-port accesses, change only while idle |
| dp_rd_i | input | 1 | Data-port read strobe |
| dp_wr_i | input | 1 | Data-port write strobe |
| dp_wdata_i | input | 16 | Data-port write data, low byte used in byte mode |
| dp_rdata_o | output | 16 | Data-port read data, upper byte zero in byte mode |

## Verification
The assertions check on every cycle that the completion flag rises only as the engine falls idle, that each counted access lowers the count, that an abort leaves the engine idle, that arming with a zero count does nothing, and that the current address holds without an access or a host load. Only the bench scenarios can show where data actually lands in memory and what comes back. That includes the little-endian word layout, the zero-wait prefetch value after arming and after each read, and the fact that idle or wrong-direction accesses leave the stored bytes intact. The bench shows these by comparing the data port against a byte-array model on every clock.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_RD    = 3'd1,
    CMD_WR    = 3'd2,
    CMD_SEND  = 3'd3,
    CMD_ABORT = 3'd4
  } cmd_e;

  localparam logic [3:0] REG_CMD    = 4'd0;
  localparam logic [3:0] REG_STS    = 4'd1;
  localparam logic [3:0] REG_CUR_WL = 4'd2;
  localparam logic [3:0] REG_CUR_WH = 4'd3;
  localparam logic [3:0] REG_CNT_L  = 4'd4;
  localparam logic [3:0] REG_CNT_H  = 4'd5;
  localparam logic [3:0] REG_CUR_RL = 4'd6;
  localparam logic [3:0] REG_CUR_RH = 4'd7;

  localparam int DONE_BIT = 6;
endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic [2:0]    cmd_i,
  input  logic          cnt_lo_we_i,
  input  logic          cnt_hi_we_i,
  input  logic [7:0]    wdata_i,
  input  logic          done_clr_i,
  input  logic          dp_rd_i,
  input  logic          dp_wr_i,
  input  logic          word_mode_i,
  output logic          active_o,
  output logic          dir_wr_o,
  output logic          xfer_o,
  output logic          arm_rd_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic          active_q, dir_wr_q, done_q;
  logic [CW-1:0] step;
  logic          last, arm;

  assign step   = word_mode_i ? CW'(2) : CW'(1);
  assign last   = (cnt_q <= step);
  assign arm    = cmd_we_i && (cmd_i == CMD_RD || cmd_i == CMD_WR) && (cnt_q != '0);
  assign xfer_o = active_q && !cmd_we_i && (dir_wr_q ? dp_wr_i : dp_rd_i);
  assign arm_rd_o = arm && (cmd_i == CMD_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      dir_wr_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (arm) begin
        active_q <= 1'b1;
        dir_wr_q <= (cmd_i == CMD_WR);
      end else if (cmd_we_i && cmd_i == CMD_ABORT) begin
        active_q <= 1'b0;
      end else if (xfer_o) begin
        cnt_q <= last ? '0 : cnt_q - step;
        if (last) active_q <= 1'b0;
      end
      // host count writes take precedence over the decrement
      if (cnt_lo_we_i) cnt_q[7:0]    <= wdata_i;
      if (cnt_hi_we_i) cnt_q[CW-1:8] <= wdata_i[CW-9:0];
      if (xfer_o && last)  done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign dir_wr_o = dir_wr_q;
  assign done_o   = done_q;
  assign cnt_o    = cnt_q;

  a_r7_done_ends_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $fell(active_q));
  a_r4_count_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o && !cnt_lo_we_i && !cnt_hi_we_i |=> cnt_q < $past(cnt_q));
  a_r8_abort_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i == CMD_ABORT |=> !active_q);
  a_r3_zero_count_no_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cnt_q == '0 && !active_q |=> !active_q);
endmodule

// File: rtl/rdma_addr.sv
module rdma_addr
  import rdma_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lo_we_i,
  input  logic          hi_we_i,
  input  logic [7:0]    wdata_i,
  input  logic          xfer_i,
  input  logic          word_mode_i,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] cur_q;

  assign nxt_o = cur_q + (word_mode_i ? AW'(2) : AW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
    end else begin
      if (xfer_i)  cur_q <= nxt_o;
      if (lo_we_i) cur_q[7:0]    <= wdata_i;
      if (hi_we_i) cur_q[AW-1:8] <= wdata_i[AW-9:0];
    end
  end

  assign cur_o = cur_q;

  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i && !lo_we_i && !hi_we_i |=> $stable(cur_q));
endmodule

// File: rtl/rdma_mem.sv
module rdma_mem #(
  parameter int MAW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic           word_i,
  input  logic [MAW-1:0] addr_i,
  input  logic [15:0]    wdata_i,
  input  logic           pf_ld_i,
  input  logic [MAW-1:0] pf_addr_i,
  output logic [15:0]    pf_o
);
  localparam int DEPTH = 1 << MAW;

  logic [7:0]  mem_q [DEPTH];
  logic [15:0] pf_q;
  logic [MAW-1:0] addr_p1, pf_p1;

  assign addr_p1 = addr_i + MAW'(1);
  assign pf_p1   = pf_addr_i + MAW'(1);

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      mem_q[addr_i] <= wdata_i[7:0];
      if (word_i) mem_q[addr_p1] <= wdata_i[15:8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pf_q <= '0;
    else if (pf_ld_i) pf_q <= {word_i ? mem_q[pf_p1] : 8'h00, mem_q[pf_addr_i]};
  end

  assign pf_o = pf_q;
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic        word_mode_i,
  input  logic        dp_rd_i,
  input  logic        dp_wr_i,
  input  logic [15:0] dp_wdata_i,
  output logic [15:0] dp_rdata_o
);
  logic              active, dir_wr, xfer, arm_rd, done;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] cur, nxt;
  logic [2:0]        cmd_rb;

  rdma_ctrl #(.CW(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .cmd_we_i    (reg_we_i && reg_addr_i == REG_CMD),
    .cmd_i       (reg_wdata_i[5:3]),
    .cnt_lo_we_i (reg_we_i && reg_addr_i == REG_CNT_L),
    .cnt_hi_we_i (reg_we_i && reg_addr_i == REG_CNT_H),
    .wdata_i     (reg_wdata_i),
    .done_clr_i  (reg_we_i && reg_addr_i == REG_STS && reg_wdata_i[DONE_BIT]),
    .dp_rd_i, .dp_wr_i, .word_mode_i,
    .active_o (active), .dir_wr_o (dir_wr), .xfer_o (xfer),
    .arm_rd_o (arm_rd), .done_o (done), .cnt_o (cnt)
  );

  rdma_addr #(.AW(ADDR_W)) u_addr (
    .clk_i, .rst_ni,
    .lo_we_i (reg_we_i && reg_addr_i == REG_CUR_WL),
    .hi_we_i (reg_we_i && reg_addr_i == REG_CUR_WH),
    .wdata_i (reg_wdata_i),
    .xfer_i  (xfer),
    .word_mode_i,
    .cur_o (cur), .nxt_o (nxt)
  );

  rdma_mem #(.MAW(MEM_AW)) u_mem (
    .clk_i, .rst_ni,
    .we_i      (xfer && dir_wr),
    .word_i    (word_mode_i),
    .addr_i    (cur[MEM_AW-1:0]),
    .wdata_i   (dp_wdata_i),
    .pf_ld_i   (arm_rd || (xfer && !dir_wr)),
    .pf_addr_i (arm_rd ? cur[MEM_AW-1:0] : nxt[MEM_AW-1:0]),
    .pf_o      (dp_rdata_o)
  );

  assign cmd_rb = !active ? CMD_ABORT : (dir_wr ? CMD_WR : CMD_RD);

  always_comb begin
    reg_rdata_o = 8'h00;
    case (reg_addr_i)
      REG_CMD:    reg_rdata_o = {2'b00, cmd_rb, 3'b000};
      REG_STS:    reg_rdata_o[DONE_BIT] = done;
      REG_CNT_L:  reg_rdata_o = cnt[7:0];
      REG_CNT_H:  reg_rdata_o = cnt[15:8];
      REG_CUR_RL: reg_rdata_o = cur[7:0];
      REG_CUR_RH: reg_rdata_o = cur[15:8];
      default:    reg_rdata_o = 8'h00;
    endcase
  end
endmodule

// File: tb/rdma_engine_tb.sv
module rdma_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        word_mode = 1'b0;
  logic        dp_rd = 1'b0, dp_wr = 1'b0;
  logic [15:0] dp_wdata = '0;
  logic [15:0] dp_rdata;

  int vectors = 0, fails = 0;

  // reference model
  int m_mem [256];
  int m_cur, m_cnt;
  bit m_act, m_dir, m_done;

  always #10 clk = ~clk;

  rdma_engine dut_i (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .word_mode_i(word_mode),
    .dp_rd_i(dp_rd), .dp_wr_i(dp_wr), .dp_wdata_i(dp_wdata), .dp_rdata_o(dp_rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mreg(input int a);
    case (a)
      0: return {2'b00, (m_act ? (m_dir ? 3'd2 : 3'd1) : 3'd4), 3'b000};
      1: return m_done ? 8'h40 : 8'h00;
      4: return 8'(m_cnt);
      5: return 8'(m_cnt >> 8);
      6: return 8'(m_cur);
      7: return 8'(m_cur >> 8);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model(input bit we, input int a, input int d, input bit dw, input bit dr, input int dd);
    int stp;
    bit xf;
    stp = word_mode ? 2 : 1;
    xf = m_act && !(we && a == 0) && (m_dir ? dw : dr);
    if (we) begin
      case (a)
        0: begin
          int c = (d >> 3) & 7;
          if ((c == 1 || c == 2) && m_cnt != 0) begin m_act = 1; m_dir = (c == 2); end
          else if (c == 4) m_act = 0;
        end
        1: if (d & 8'h40) m_done = 0;
        2: m_cur = (m_cur & 16'hFF00) | d;
        3: m_cur = (m_cur & 16'h00FF) | (d << 8);
        4: m_cnt = (m_cnt & 16'hFF00) | d;
        5: m_cnt = (m_cnt & 16'h00FF) | (d << 8);
        default: ;
      endcase
    end
    if (xf) begin
      if (m_dir) begin
        m_mem[m_cur % 256] = dd & 255;
        if (word_mode) m_mem[(m_cur + 1) % 256] = (dd >> 8) & 255;
      end
      m_cur = (m_cur + stp) % 65536;
      if (m_cnt <= stp) begin m_cnt = 0; m_act = 0; m_done = 1; end
      else m_cnt = m_cnt - stp;
    end
  endtask

  task automatic cyc(input bit we, input int a, input int d, input bit dw, input bit dr, input int dd);
    reg_we = we; reg_addr = 4'(a); reg_wdata = 8'(d);
    dp_wr = dw; dp_rd = dr; dp_wdata = 16'(dd);
    @(posedge clk);
    model(we, a, d, dw, dr, dd);
    @(negedge clk);
    reg_we = 0; dp_wr = 0; dp_rd = 0;
    if (m_act && !m_dir)
      chk("R5 prefetch per cycle", dp_rdata,
          word_mode ? 16'((m_mem[(m_cur + 1) % 256] << 8) | m_mem[m_cur % 256])
                    : 16'(m_mem[m_cur % 256]));
  endtask

  task automatic wreg(input int a, input int d); cyc(1, a, d, 0, 0, 0); endtask
  task automatic dpw(input int d); cyc(0, 0, 0, 1, 0, d); endtask
  task automatic dpr(); cyc(0, 0, 0, 0, 1, 0); endtask

  task automatic rd(input int a, input logic [7:0] exp, input string tag);
    reg_addr = 4'(a);
    #1;
    chk(tag, {8'h00, reg_rdata}, {8'h00, exp});
    chk({tag, " model"}, {8'h00, reg_rdata}, {8'h00, mreg(a)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    foreach (m_mem[i]) m_mem[i] = 0;
    m_cur = 0; m_cnt = 0; m_act = 0; m_dir = 0; m_done = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd(0, 8'h20, "R1 cmd readback");
    rd(1, 8'h00, "R1 status");
    rd(4, 8'h00, "R1 count lo");
    rd(6, 8'h00, "R1 cur lo");
    rd(7, 8'h00, "R1 cur hi");
    chk("R1 data port", dp_rdata, 16'h0000);

    // fill 0x00..0x1F
    wreg(2, 0); wreg(3, 0); wreg(4, 32); wreg(5, 0); wreg(0, 8'h10);
    for (int i = 0; i < 32; i++) dpw(i ^ 8'h5A);
    rd(1, 8'h40, "R7 done after fill");
    rd(6, 8'h20, "R4 cur after fill");
    wreg(1, 8'h40);
    rd(1, 8'h00, "R7 done cleared");

    // R2 R3 R4 byte write
    wreg(2, 8'h10); wreg(3, 8'h00);
    rd(6, 8'h10, "R2 cur lo");
    rd(7, 8'h00, "R2 cur hi");
    wreg(4, 5);
    rd(4, 8'h05, "R3 count readback");
    wreg(0, 8'h10);
    rd(0, 8'h10, "R3 write armed");
    for (int i = 0; i < 5; i++) dpw(8'hA0 + i);
    rd(6, 8'h15, "R4 cur advanced");
    rd(1, 8'h40, "R7 done set");
    rd(0, 8'h20, "R7 idle after done");

    // R9 idle access ignored
    dpw(8'hEE);
    rd(6, 8'h15, "R9 idle cur unchanged");
    wreg(1, 8'h40);

    // R5 read back with prefetch
    wreg(2, 8'h10); wreg(4, 6); wreg(0, 8'h08);
    chk("R5 first byte after arm", dp_rdata, 16'h00A0);
    for (int i = 0; i < 5; i++) dpr();
    chk("R9 idle write left memory", dp_rdata, 16'h004F);
    dpw(8'h77);
    rd(6, 8'h15, "R9 wrong direction ignored");
    chk("R9 wrong direction data", dp_rdata, 16'h004F);
    dpr();
    rd(1, 8'h40, "R7 done after read");
    wreg(1, 8'h40);

    // R3 zero count and other codes
    wreg(4, 0); wreg(5, 0); wreg(0, 8'h08);
    rd(0, 8'h20, "R3 zero count no arm");
    wreg(4, 3); wreg(0, 8'h18);
    rd(0, 8'h20, "R3 code 3 no effect");

    // R8 abort
    wreg(2, 8'h20); wreg(4, 4); wreg(0, 8'h10);
    dpw(8'h11); dpw(8'h22);
    wreg(0, 8'h20);
    rd(0, 8'h20, "R8 idle after abort");
    dpw(8'h33);
    rd(6, 8'h22, "R8 cur held");
    rd(4, 8'h02, "R8 count held");
    rd(1, 8'h00, "R8 no done");

    // R6 word mode
    word_mode = 1'b1;
    wreg(2, 8'h30); wreg(4, 4); wreg(0, 8'h10);
    dpw(16'h1234); dpw(16'h5678);
    rd(6, 8'h34, "R6 cur +2 per word");
    rd(1, 8'h40, "R6 done after words");
    wreg(1, 8'h40);
    wreg(2, 8'h30); wreg(4, 4); wreg(0, 8'h08);
    chk("R6 word read 0", dp_rdata, 16'h1234);
    dpr();
    chk("R6 word read 1", dp_rdata, 16'h5678);
    dpr();
    word_mode = 1'b0;
    wreg(2, 8'h30); wreg(4, 2); wreg(0, 8'h08);
    chk("R6 byte order low first", dp_rdata, 16'h0034);
    dpr();
    chk("R6 byte order high next", dp_rdata, 16'h0012);
    dpr();

    // R6 odd count in word mode
    word_mode = 1'b1;
    wreg(1, 8'h40);
    wreg(2, 8'h38); wreg(4, 3); wreg(0, 8'h10);
    dpw(16'hAABB);
    rd(4, 8'h01, "R6 count -2");
    rd(1, 8'h00, "R7 no early done");
    dpw(16'hCCDD);
    rd(4, 8'h00, "R6 residual count exhausted");
    rd(1, 8'h40, "R6 done on odd count");
    rd(6, 8'h3C, "R6 cur after odd count");
    word_mode = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule